// File: doc/BRIEF.md
# SDRAM bank timing guard

This block sits beside an SDRAM command scheduler. It keeps the state of every bank (up to four row groups of four banks each). Every cycle it answers whether the command now offered may be issued. The scheduler presents one request per cycle: an opcode, a row-group index and a bank index. The block raises `cmd_grant` in the same cycle only when the command meets every programmed spacing rule. A granted command counts as issued at the next rising clock edge.

The timing rules come from a 32-bit configuration word, held in a register that software loads through `cfg_we`. Each bank has a small state machine with the states CLOSED, ACTIVATING, OPEN and PRECHARGING. The named transitions are: activate (CLOSED to ACTIVATING), row-ready when the RAS-to-CAS counter reaches its last count (ACTIVATING to OPEN), close when a precharge is accepted (OPEN to PRECHARGING), and precharge-done when the precharge counter reaches its last count (PRECHARGING to CLOSED).

Each bank also has a maximum-open-time counter, which requests a forced precharge once the bank has been open too long. A shared idle timer has the states WAIT and PEND. It moves from WAIT to PEND (expire) when no command has been accepted for the programmed idle time while a page is open. It moves back to WAIT (acknowledge) when a precharge-all is accepted. While in PEND it requests a precharge-all. The block also decodes the CAS latency field for the data path; it does not use that value in its own checks.

Top module: `sdg_bank_guard`

## Requirements
- R1: After reset the configuration register holds zero, no bank is open, `force_pre_req` and `pre_all_req` are low, `cfg_error` is high because the zero word holds reserved codes, and `cas_half_clks` reads 6.
- R2: Config bits [1:0] give the activate-to-read/write delay D (01 = 3 clocks, 10 = 2 clocks). A read or write to a bank is granted no sooner than D cycles after the cycle its activate was accepted, and exactly then when it is offered every cycle.
- R3: Config bits [3:2] give the precharge-to-activate delay D (01 = 3, 10 = 2). An activate to a bank is granted first D cycles after the cycle its precharge was accepted.
- R4: Config bits [5:4] give the minimum active time (00 = 8, 01 = 7, 10 = 6, 11 = 5 clocks). A precharge to a bank, and a precharge-all for every bank, is granted first that many cycles after the bank's activate.
- R5: For codes 00 and 11 in bits [1:0] or [3:2] the 3-clock delay applies. Idle codes 101 to 111 act as "never". A reserved CAS code reports the longest latency of its mode. Any of these, or any set bit in [31:12], raises `cfg_error`. A word written with `cfg_we` takes effect in the next cycle.
- R6: Opcodes are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all; 0, 6 and 7 are never granted. The bank number is {group, bank}. An activate needs a closed bank, and a read or write needs an open bank.
- R7: `force_pre_req[i]` rises exactly MAX_OPEN_NS*1000/CLK_PERIOD_PS cycles after the activate cycle of bank i (24000 at defaults). While it is high, reads and writes to bank i are stalled. It falls in the cycle after the bank's precharge is accepted.
- R8: Config bits [8:6] set the idle limit N (001 = 0, 010 = 8, 011 = 16, 100 = 64). While some bank is activating or open, `pre_all_req` becomes high N+2 cycles after the cycle of the last accepted command.
- R9: With idle code 000, or while every bank is closed or precharging, `pre_all_req` stays low.
- R10: `pre_all_req` stays high until a precharge-all is accepted. In the next cycle it is low and every bank has left the open state.
- R11: A command accepted in the cycle in which the idle limit is reached cancels the request, and the count restarts from that command.
- R12: Bit [11] selects DDR mode and bits [10:9] the CAS code. `cas_half_clks` gives the latency in half clocks: SDR 01 = 6, 10 = 4; DDR 00 = 5, 01 = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the configuration register |
| cfg_wdata | input | 32 | New configuration word |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_group | input | 2 | Row-group index (log2 NUM_GROUPS) |
| cmd_bank | input | 2 | Bank index within the group (log2 BANKS_PER_GROUP) |
| cmd_grant | output | 1 | The offered command is legal and is taken at the next edge |
| bank_open | output | 16 | Per bank: open, reads and writes allowed by timing |
| force_pre_req | output | 16 | Per bank: maximum open time reached |
| pre_all_req | output | 1 | Idle time expired; precharge-all requested |
| cas_half_clks | output | 4 | Decoded CAS latency in half clocks |
| cfg_error | output | 1 | The configuration holds a reserved code |

## Verification
The idle timer's expiry and the acceptance of an ordinary command can fall in the same cycle. The bench sets an idle limit of 8 and opens a bank. It then offers a read to that bank in exactly the cycle in which the idle count reaches the limit, so the read is granted in the expiry cycle. The check is that the precharge-all request stays low in the following cycle. A second check confirms that the request then appears N+2 cycles after the read, which shows the count restarted from the read.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_PREA = 3'd5
    } sdg_op_e;

    typedef enum logic [1:0] {
        BK_CLOSED,
        BK_ACTIVATING,
        BK_OPEN,
        BK_PRECHARGING
    } sdg_bank_state_e;

    typedef enum logic {
        IT_WAIT,
        IT_PEND
    } sdg_idle_state_e;

    typedef struct packed {
        logic [1:0] rcd_cyc;
        logic [1:0] rp_cyc;
        logic [3:0] ras_cyc;
        logic       idle_en;
        logic [6:0] idle_lim;
        logic [3:0] cas_half;
        logic       err;
    } sdg_timing_t;

endpackage

// File: rtl/sdg_cfg_decode.sv
module sdg_cfg_decode
    import sdg_pkg::*;
(
    input  logic [31:0] cfg_word,
    output sdg_timing_t tim
);
    logic [1:0] rcd_code, rp_code, ras_code, cas_code;
    logic [2:0] idle_code;
    logic       ddr_mode;
    logic       rcd_bad, rp_bad, idle_bad, cas_bad;

    assign rcd_code  = cfg_word[1:0];
    assign rp_code   = cfg_word[3:2];
    assign ras_code  = cfg_word[5:4];
    assign idle_code = cfg_word[8:6];
    assign cas_code  = cfg_word[10:9];
    assign ddr_mode  = cfg_word[11];

    always_comb begin
        rcd_bad  = 1'b0;
        rp_bad   = 1'b0;
        idle_bad = 1'b0;
        cas_bad  = 1'b0;
        tim      = '0;

        unique case (rcd_code)
            2'b01:   tim.rcd_cyc = 2'd3;
            2'b10:   tim.rcd_cyc = 2'd2;
            default: begin tim.rcd_cyc = 2'd3; rcd_bad = 1'b1; end
        endcase

        unique case (rp_code)
            2'b01:   tim.rp_cyc = 2'd3;
            2'b10:   tim.rp_cyc = 2'd2;
            default: begin tim.rp_cyc = 2'd3; rp_bad = 1'b1; end
        endcase

        tim.ras_cyc = 4'd8 - {2'b00, ras_code};

        unique case (idle_code)
            3'b000:  tim.idle_en = 1'b0;
            3'b001:  begin tim.idle_en = 1'b1; tim.idle_lim = 7'd0;  end
            3'b010:  begin tim.idle_en = 1'b1; tim.idle_lim = 7'd8;  end
            3'b011:  begin tim.idle_en = 1'b1; tim.idle_lim = 7'd16; end
            3'b100:  begin tim.idle_en = 1'b1; tim.idle_lim = 7'd64; end
            default: begin tim.idle_en = 1'b0; idle_bad = 1'b1; end
        endcase

        if (ddr_mode) begin
            unique case (cas_code)
                2'b00:   tim.cas_half = 4'd5;
                2'b01:   tim.cas_half = 4'd4;
                default: begin tim.cas_half = 4'd5; cas_bad = 1'b1; end
            endcase
        end else begin
            unique case (cas_code)
                2'b01:   tim.cas_half = 4'd6;
                2'b10:   tim.cas_half = 4'd4;
                default: begin tim.cas_half = 4'd6; cas_bad = 1'b1; end
            endcase
        end

        tim.err = rcd_bad | rp_bad | idle_bad | cas_bad | (|cfg_word[31:12]);
    end
endmodule

// File: rtl/sdg_bank.sv
module sdg_bank
    import sdg_pkg::*;
#(
    parameter int MAX_OPEN_CYC = 24000,
    parameter int OPEN_W       = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rcd_cyc,
    input  logic [1:0] rp_cyc,
    input  logic [3:0] ras_cyc,
    input  logic       act_go,
    input  logic       pre_go,
    output logic       act_ok,
    output logic       rw_ok,
    output logic       pre_ok,
    output logic       is_open,
    output logic       in_use,
    output logic       expired
);
    localparam logic [OPEN_W-1:0] OPEN_MAX = OPEN_W'(MAX_OPEN_CYC);

    sdg_bank_state_e   st, nxt;
    logic [1:0]        rcd_cnt, rp_cnt;
    logic [2:0]        ras_cnt;
    logic [OPEN_W-1:0] open_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= BK_CLOSED;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            BK_CLOSED:      if (act_go)         nxt = BK_ACTIVATING;
            BK_ACTIVATING:  if (rcd_cnt == 2'd1) nxt = BK_OPEN;
            BK_OPEN:        if (pre_go)         nxt = BK_PRECHARGING;
            BK_PRECHARGING: if (rp_cnt == 2'd1)  nxt = BK_CLOSED;
            default:                            nxt = BK_CLOSED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcd_cnt  <= '0;
            rp_cnt   <= '0;
            ras_cnt  <= '0;
            open_cnt <= '0;
        end else begin
            if (act_go)               rcd_cnt <= rcd_cyc - 2'd1;
            else if (rcd_cnt != 2'd0) rcd_cnt <= rcd_cnt - 2'd1;

            if (act_go)               ras_cnt <= 3'(ras_cyc - 4'd1);
            else if (ras_cnt != 3'd0) ras_cnt <= ras_cnt - 3'd1;

            if (pre_go && st == BK_OPEN) rp_cnt <= rp_cyc - 2'd1;
            else if (rp_cnt != 2'd0)     rp_cnt <= rp_cnt - 2'd1;

            if (act_go)                           open_cnt <= OPEN_W'(1);
            else if (in_use && open_cnt != OPEN_MAX) open_cnt <= open_cnt + OPEN_W'(1);
            else if (!in_use)                     open_cnt <= '0;
        end
    end

    always_comb begin
        in_use  = (st == BK_ACTIVATING) || (st == BK_OPEN);
        is_open = (st == BK_OPEN);
        expired = in_use && (open_cnt == OPEN_MAX);
        act_ok  = (st == BK_CLOSED);
        rw_ok   = is_open && !expired;
        pre_ok  = (st != BK_ACTIVATING) && (ras_cnt == 3'd0);
    end
endmodule

// File: rtl/sdg_idle_timer.sv
module sdg_idle_timer
    import sdg_pkg::*;
#(
    parameter int LIM_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_acc,
    input  logic             prea_acc,
    input  logic             any_in_use,
    input  logic             idle_en,
    input  logic [LIM_W-1:0] idle_lim,
    output logic             req
);
    sdg_idle_state_e  st, nxt;
    logic [LIM_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= IT_WAIT;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            IT_WAIT: if (!cmd_acc && idle_en && any_in_use && cnt >= idle_lim) nxt = IT_PEND;
            IT_PEND: if (prea_acc) nxt = IT_WAIT;
            default: nxt = IT_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (cmd_acc)    cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + LIM_W'(1);
    end

    always_comb req = (st == IT_PEND);
endmodule

// File: rtl/sdg_bank_guard.sv
module sdg_bank_guard
    import sdg_pkg::*;
#(
    parameter int NUM_GROUPS      = 4,
    parameter int BANKS_PER_GROUP = 4,
    parameter int CLK_PERIOD_PS   = 5000,
    parameter int MAX_OPEN_NS     = 120000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_we,
    input  logic [31:0]                           cfg_wdata,
    input  logic                                  cmd_valid,
    input  logic [2:0]                            cmd_op,
    input  logic [$clog2(NUM_GROUPS)-1:0]         cmd_group,
    input  logic [$clog2(BANKS_PER_GROUP)-1:0]    cmd_bank,
    output logic                                  cmd_grant,
    output logic [NUM_GROUPS*BANKS_PER_GROUP-1:0] bank_open,
    output logic [NUM_GROUPS*BANKS_PER_GROUP-1:0] force_pre_req,
    output logic                                  pre_all_req,
    output logic [3:0]                            cas_half_clks,
    output logic                                  cfg_error
);
    localparam int NUM_BANKS    = NUM_GROUPS * BANKS_PER_GROUP;
    localparam int GRP_W        = $clog2(NUM_GROUPS);
    localparam int BNK_W        = $clog2(BANKS_PER_GROUP);
    localparam int IDX_W        = GRP_W + BNK_W;
    localparam int MAX_OPEN_CYC = (MAX_OPEN_NS * 1000) / CLK_PERIOD_PS;
    localparam int OPEN_W       = $clog2(MAX_OPEN_CYC + 1);

    logic [31:0]          cfg_q;
    sdg_timing_t          tim;
    sdg_op_e              op;
    logic [IDX_W-1:0]     sel_idx;
    logic                 legal;
    logic [NUM_BANKS-1:0] act_ok, rw_ok, pre_ok, in_use, act_go, pre_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    sdg_cfg_decode u_dec (
        .cfg_word (cfg_q),
        .tim      (tim)
    );

    assign op      = sdg_op_e'(cmd_op);
    assign sel_idx = {cmd_group, cmd_bank};

    always_comb begin
        unique case (op)
            OP_ACT:        legal = act_ok[sel_idx];
            OP_RD, OP_WR:  legal = rw_ok[sel_idx];
            OP_PRE:        legal = pre_ok[sel_idx];
            OP_PREA:       legal = &pre_ok;
            default:       legal = 1'b0;
        endcase
    end

    assign cmd_grant = cmd_valid && legal;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        assign act_go[i] = cmd_grant && (op == OP_ACT) && (sel_idx == IDX_W'(i));
        assign pre_go[i] = cmd_grant && ((op == OP_PREA) ||
                                         ((op == OP_PRE) && (sel_idx == IDX_W'(i))));
        sdg_bank #(
            .MAX_OPEN_CYC (MAX_OPEN_CYC),
            .OPEN_W       (OPEN_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rcd_cyc (tim.rcd_cyc),
            .rp_cyc  (tim.rp_cyc),
            .ras_cyc (tim.ras_cyc),
            .act_go  (act_go[i]),
            .pre_go  (pre_go[i]),
            .act_ok  (act_ok[i]),
            .rw_ok   (rw_ok[i]),
            .pre_ok  (pre_ok[i]),
            .is_open (bank_open[i]),
            .in_use  (in_use[i]),
            .expired (force_pre_req[i])
        );
    end

    sdg_idle_timer #(.LIM_W(7)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_acc    (cmd_grant),
        .prea_acc   (cmd_grant && (op == OP_PREA)),
        .any_in_use (|in_use),
        .idle_en    (tim.idle_en),
        .idle_lim   (tim.idle_lim),
        .req        (pre_all_req)
    );

    assign cas_half_clks = tim.cas_half;
    assign cfg_error     = tim.err;
endmodule

// File: rtl/sdg_bank_guard_chk.sv
module sdg_bank_guard_chk #(
    parameter int IDX_W     = 4,
    parameter int NUM_BANKS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [2:0]           cmd_op,
    input logic [IDX_W-1:0]     cmd_idx,
    input logic                 cmd_grant,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [NUM_BANKS-1:0] force_pre_req,
    input logic                 pre_all_req,
    input logic                 cfg_error,
    input logic [1:0]           cfg_rcd_code
);
    AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_grant |-> cmd_valid); // R6

    AST_ACT_NOT_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_grant && cmd_op == 3'd1) |-> !bank_open[cmd_idx]); // R6

    AST_OPEN_WAITS_RCD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_grant && cmd_op == 3'd1) |=> !bank_open[$past(cmd_idx)]); // R2

    AST_RW_NOT_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_grant && (cmd_op == 3'd2 || cmd_op == 3'd3))
            |-> (bank_open[cmd_idx] && !force_pre_req[cmd_idx])); // R7

    AST_PREALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_all_req && !(cmd_grant && cmd_op == 3'd5)) |=> pre_all_req); // R10

    AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_grant && cmd_op == 3'd5)
            |=> (bank_open == '0 && force_pre_req == '0 && !pre_all_req)); // R10

    AST_CMD_BEATS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_all_req && cmd_grant) |=> !pre_all_req); // R11

    AST_RESERVED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rcd_code == 2'b00 || cfg_rcd_code == 2'b11) |-> cfg_error); // R5
endmodule

bind sdg_bank_guard sdg_bank_guard_chk #(
    .IDX_W     (IDX_W),
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_idx       ({cmd_group, cmd_bank}),
    .cmd_grant     (cmd_grant),
    .bank_open     (bank_open),
    .force_pre_req (force_pre_req),
    .pre_all_req   (pre_all_req),
    .cfg_error     (cfg_error),
    .cfg_rcd_code  (cfg_q[1:0])
);

// File: tb/sdg_bank_guard_bench.sv
module sdg_bank_guard_bench;
    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                           C_PRE = 3'd4, C_PREA = 3'd5;
    localparam int OPEN_LIMIT = 120000 * 1000 / 5000;

    typedef struct packed {
        logic [1:0] rcd_code;
        logic [1:0] rp_code;
        logic [1:0] ras_code;
        logic [3:0] exp_rcd;
        logic [3:0] exp_rp;
        logic [3:0] exp_ras;
        logic       exp_err;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VEC [NV] = '{
        '{2'b01, 2'b01, 2'b00, 4'd3, 4'd3, 4'd8, 1'b0},
        '{2'b10, 2'b10, 2'b01, 4'd2, 4'd2, 4'd7, 1'b0},
        '{2'b11, 2'b00, 2'b10, 4'd3, 4'd3, 4'd6, 1'b1},
        '{2'b00, 2'b11, 2'b11, 4'd3, 4'd3, 4'd5, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_group = '0;
    logic [1:0]  cmd_bank = '0;
    logic        cmd_grant;
    logic [15:0] bank_open, force_pre_req;
    logic        pre_all_req;
    logic [3:0]  cas_half_clks;
    logic        cfg_error;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    sdg_bank_guard u_sdg_bank_guard (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_group (cmd_group),
        .cmd_bank (cmd_bank), .cmd_grant (cmd_grant), .bank_open (bank_open),
        .force_pre_req (force_pre_req), .pre_all_req (pre_all_req),
        .cas_half_clks (cas_half_clks), .cfg_error (cfg_error)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input logic [1:0] rcd, input logic [1:0] rp,
                                          input logic [1:0] ras, input logic [2:0] idle,
                                          input logic [1:0] cas, input logic ddr);
        return {20'd0, ddr, cas, idle, ras, rp, rcd};
    endfunction

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_we = 1'b0; #1;
    endtask

    task automatic poll(input logic [2:0] op, input int g, input int b, output int n);
        n = 0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            n++;
            cmd_valid = 1'b1; cmd_op = op; cmd_group = 2'(g); cmd_bank = 2'(b);
            #1;
            if (cmd_grant) begin
                @(posedge clk);
                return;
            end
        end
        n = -1;
    endtask

    task automatic drop();
        @(negedge clk); cmd_valid = 1'b0; #1;
    endtask

    task automatic drive(input logic [2:0] op, input int g, input int b);
        cmd_valid = 1'b1; cmd_op = op; cmd_group = 2'(g); cmd_bank = 2'(b); #1;
    endtask

    task automatic idle_case(input logic [2:0] code, input int lim, input int b);
        int n;
        write_cfg(mk_cfg(2'b01, 2'b01, 2'b00, code, 2'b01, 1'b0));
        poll(C_ACT, 0, b, n);
        drop();
        repeat (lim) @(negedge clk);
        #1; check($sformatf("R8 idle %0d not early", lim), int'(pre_all_req), 0);
        @(negedge clk); #1;
        check($sformatf("R8 idle %0d raised", lim), int'(pre_all_req), 1);
        repeat (5) @(negedge clk);
        #1; check("R10 request held", int'(pre_all_req), 1);
        poll(C_PREA, 0, 0, n);
        drop();
        check("R10 request cleared", int'(pre_all_req), 0);
        check("R10 banks closed", int'(bank_open), 0);
        repeat (10) @(negedge clk);
        #1; check("R9 no request when closed", int'(pre_all_req), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;

        // R1 reset state
        check("R1 no bank open", int'(bank_open), 0);
        check("R1 no forced precharge", int'(force_pre_req), 0);
        check("R1 no precharge-all", int'(pre_all_req), 0);
        check("R1 error on zero word", int'(cfg_error), 1);
        check("R1 cas on zero word", int'(cas_half_clks), 6);

        // Vector walk: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            int g = v;
            int b = 3 - v;
            write_cfg(mk_cfg(VEC[v].rcd_code, VEC[v].rp_code, VEC[v].ras_code,
                             3'b000, 2'b01, 1'b0));
            check($sformatf("R5 error flag vec %0d", v), int'(cfg_error), int'(VEC[v].exp_err));
            poll(C_ACT, g, b, n);
            poll(C_PRE, g, b, n);
            check($sformatf("R4 act-to-pre vec %0d", v), n, int'(VEC[v].exp_ras));
            poll(C_ACT, g, b, n);
            check($sformatf("R3 pre-to-act vec %0d", v), n, int'(VEC[v].exp_rp));
            poll(C_RD, g, b, n);
            check($sformatf("R2 act-to-rd vec %0d", v), n, int'(VEC[v].exp_rcd));
            poll(C_PRE, g, b, n);
            check($sformatf("R4 rd-to-pre vec %0d", v), n,
                  int'(VEC[v].exp_ras) - int'(VEC[v].exp_rcd));
            drop();
            repeat (4) @(negedge clk);
        end

        // R6 illegal commands stall
        write_cfg(mk_cfg(2'b01, 2'b01, 2'b00, 3'b000, 2'b01, 1'b0));
        check("R5 clean word no error", int'(cfg_error), 0);
        poll(C_ACT, 0, 0, n);
        @(negedge clk);
        drive(C_ACT, 0, 0);  check("R6 act on busy bank", int'(cmd_grant), 0);
        drive(C_RD, 0, 1);   check("R6 read on closed bank", int'(cmd_grant), 0);
        drive(C_NOP, 0, 1);  check("R6 no-op never granted", int'(cmd_grant), 0);
        drive(3'd6, 0, 1);   check("R6 opcode 6 never granted", int'(cmd_grant), 0);
        drive(C_PREA, 0, 0); check("R4 prea before tras", int'(cmd_grant), 0);
        drive(C_ACT, 0, 1);  check("R6 act other bank", int'(cmd_grant), 1);
        @(posedge clk);
        poll(C_PREA, 0, 0, n);
        drop();
        repeat (4) @(negedge clk);

        // R12 CAS decode and R5 reserved codes
        write_cfg(mk_cfg(2'b01, 2'b01, 2'b00, 3'b000, 2'b10, 1'b0));
        check("R12 sdr code 10", int'(cas_half_clks), 4);
        write_cfg(mk_cfg(2'b01, 2'b01, 2'b00, 3'b000, 2'b00, 1'b1));
        check("R12 ddr code 00", int'(cas_half_clks), 5);
        write_cfg(mk_cfg(2'b01, 2'b01, 2'b00, 3'b000, 2'b01, 1'b1));
        check("R12 ddr code 01", int'(cas_half_clks), 4);
        check("R12 ddr code 01 no error", int'(cfg_error), 0);
        write_cfg(mk_cfg(2'b01, 2'b01, 2'b00, 3'b000, 2'b11, 1'b1));
        check("R5 ddr reserved cas", int'(cas_half_clks), 5);
        check("R5 ddr reserved cas error", int'(cfg_error), 1);
        write_cfg(mk_cfg(2'b01, 2'b01, 2'b00, 3'b000, 2'b01, 1'b0) | 32'h0010_0000);
        check("R5 upper bit error", int'(cfg_error), 1);

        // R8 R9 R10 idle timer codes
        idle_case(3'b010, 8, 2);
        idle_case(3'b011, 16, 2);
        idle_case(3'b001, 0, 2);
        idle_case(3'b100, 64, 2);

        // R9 idle disabled, R5 reserved idle code
        write_cfg(mk_cfg(2'b01, 2'b01, 2'b00, 3'b000, 2'b01, 1'b0));
        poll(C_ACT, 1, 0, n);
        drop();
        repeat (80) @(negedge clk);
        #1; check("R9 idle code 000", int'(pre_all_req), 0);
        write_cfg(mk_cfg(2'b01, 2'b01, 2'b00, 3'b101, 2'b01, 1'b0));
        check("R5 reserved idle error", int'(cfg_error), 1);
        repeat (80) @(negedge clk);
        #1; check("R5 reserved idle never", int'(pre_all_req), 0);
        poll(C_PRE, 1, 0, n);
        drop();
        repeat (4) @(negedge clk);

        // R11 accepted command in the expiry cycle
        write_cfg(mk_cfg(2'b01, 2'b01, 2'b00, 3'b010, 2'b01, 1'b0));
        poll(C_ACT, 1, 0, n);
        drop();
        repeat (8) @(negedge clk);
        drive(C_RD, 1, 0);
        check("R11 read granted at expiry", int'(cmd_grant), 1);
        @(negedge clk); cmd_valid = 1'b0; #1;
        check("R11 request cancelled", int'(pre_all_req), 0);
        repeat (8) @(negedge clk);
        #1; check("R11 restart not early", int'(pre_all_req), 0);
        @(negedge clk); #1;
        check("R11 restart raised", int'(pre_all_req), 1);
        poll(C_PREA, 0, 0, n);
        drop();
        repeat (4) @(negedge clk);

        // R7 maximum open time
        write_cfg(mk_cfg(2'b01, 2'b01, 2'b00, 3'b000, 2'b01, 1'b0));
        poll(C_ACT, 1, 1, n);
        drop();
        repeat (OPEN_LIMIT - 2) @(negedge clk);
        #1; check("R7 not expired early", int'(force_pre_req[5]), 0);
        check("R7 only bank 5 tracked", int'(force_pre_req), 0);
        @(negedge clk); #1;
        check("R7 expired at limit", int'(force_pre_req[5]), 1);
        drive(C_RD, 1, 1);
        check("R7 read stalled when expired", int'(cmd_grant), 0);
        poll(C_PRE, 1, 1, n);
        check("R7 precharge granted at once", n, 1);
        drop();
        check("R7 request cleared", int'(force_pre_req), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule